// File: doc/BRIEF.md
# Page Permission Check Unit

This block decides whether a memory access may use a leaf page-table entry that a table walker has already fetched. It is purely combinational. The caller presents the entry's permission flags, the kind of access (instruction fetch, load or store), an atomic-operation flag, the current privilege level and four status controls: modify-privilege enable, previous privilege, supervisor-may-touch-user-pages and make-executable-readable. In the same cycle the block answers with a grant, the exception cause to raise when the access is refused, and which trap-value register should receive the faulting address.

The walker also has a force-fail input. It uses this when the walk itself went wrong, for example on a malformed or misaligned entry. A forced failure is refused and reported with the page-fault cause that belongs to the access kind, just like a permission failure. The block does not walk tables, store translations or deliver traps.

Privilege encoding is U=0, S=1, M=3. The flag vector is bit 0 valid, bit 1 readable, bit 2 writable, bit 3 executable and bit 4 user. The access kind is 0 fetch, 1 load, 2 store, and the unused code 3 behaves as a store.

Top module: `page_perm_check`

## Requirements
- R1: The effective privilege is the previous-privilege input when modify-privilege is set and the access is a load or store. For a fetch, or when modify-privilege is clear, it is the current privilege.
- R2: An entry with the valid bit (bit 0) clear is always refused.
- R3: With effective privilege U, an entry whose user bit (bit 4) is clear is refused.
- R4: With effective privilege S, a user entry is refused for a fetch, and is refused for a load or store unless supervisor-user-access is set.
- R5: A fetch needs the executable bit (bit 3). A refused fetch reports cause 12.
- R6: A load needs the readable bit (bit 1), or the executable bit with make-executable-readable set. A refused load reports cause 13, or cause 15 when the atomic flag is set.
- R7: A store (kind 2, or the unused kind 3) needs the writable bit (bit 2). A refused store reports cause 15.
- R8: For a refused fetch, the trap-value select is 0 (supervisor register). For a refused load or store, it is 1 (machine register) exactly when the current privilege, not the effective one, is M.
- R9: When force-fail is high, the access is refused whatever the flags are, with the cause of R5 to R7 for its kind.
- R10: When the access is granted, the cause output is 0 and the trap-value select is 0.
- R11: With effective privilege M, the user bit and supervisor-user-access have no effect. Only the valid bit and the kind-specific bit decide.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| pte_perm_i | input | 5 | Entry flags {user, exec, write, read, valid} |
| acc_kind_i | input | 2 | 0 fetch, 1 load, 2 store, 3 treated as store |
| amo_i | input | 1 | Access belongs to an atomic memory operation |
| cur_priv_i | input | 2 | Current privilege level |
| mprv_i | input | 1 | Modify-privilege enable for data accesses |
| mpp_i | input | 2 | Previous privilege used when modify-privilege applies |
| sum_i | input | 1 | Supervisor may access user pages |
| mxr_i | input | 1 | Executable pages are readable by loads |
| force_fail_i | input | 1 | Caller forces a refusal |
| grant_o | output | 1 | Access permitted |
| cause_o | output | 5 | Exception cause when refused, else 0 |
| tval_to_m_o | output | 1 | 1: address to machine trap value; 0: supervisor |

## Verification
Several cases target a design that takes modify-privilege into account for fetches. Such a design would refuse a fetch that should pass when the previous privilege is U. Other cases catch a trap-value select driven from the effective privilege instead of the current one: a machine-mode store under modify-privilege would then report the supervisor register.

The atomic-load case catches a design that reports cause 13 where 15 is due. The executable-only load, tried with and without make-executable-readable, exposes a design that ignores that control. The supervisor fetch from a user page, with supervisor-user-access set, catches a design that lets that control apply to fetches. Forced failures on fully permitted entries expose a force input that is dropped or that yields the wrong cause.

// File: rtl/pgchk_pkg.sv
package pgchk_pkg;

  typedef enum logic [1:0] {
    PRIV_U   = 2'd0,
    PRIV_S   = 2'd1,
    PRIV_RSV = 2'd2,
    PRIV_M   = 2'd3
  } priv_e;

  typedef enum logic [1:0] {
    ACC_FETCH = 2'd0,
    ACC_LOAD  = 2'd1,
    ACC_STORE = 2'd2,
    ACC_RSV   = 2'd3
  } acc_e;

  typedef struct packed {
    logic u;
    logic x;
    logic w;
    logic r;
    logic v;
  } perm_t;

  localparam int PERM_W = $bits(perm_t);

endpackage

// File: rtl/pgchk_mode_sel.sv
module pgchk_mode_sel
  import pgchk_pkg::*;
(
  input  priv_e cur_priv_i,
  input  priv_e mpp_i,
  input  logic  mprv_i,
  input  logic  is_fetch_i,
  output priv_e eff_priv_o
);

  always_comb begin
    if (mprv_i && !is_fetch_i) begin
      eff_priv_o = mpp_i;
    end else begin
      eff_priv_o = cur_priv_i;
    end
  end

  always_comb begin
    if (is_fetch_i) begin
      AST_FETCH_KEEPS_MODE: assert (eff_priv_o == cur_priv_i); // R1
    end
  end

endmodule

// File: rtl/pgchk_base_ok.sv
module pgchk_base_ok
  import pgchk_pkg::*;
(
  input  logic  valid_i,
  input  logic  user_i,
  input  priv_e eff_priv_i,
  input  logic  sum_i,
  input  logic  is_fetch_i,
  input  logic  force_fail_i,
  output logic  base_ok_o
);

  logic user_block;
  logic sup_block;

  always_comb begin
    user_block = (eff_priv_i == PRIV_U) && !user_i;
    sup_block  = user_i && (eff_priv_i == PRIV_S) && (!sum_i || is_fetch_i);
    base_ok_o  = !force_fail_i && valid_i && !user_block && !sup_block;
  end

  always_comb begin
    if (force_fail_i) begin
      AST_FORCE_BLOCKS_BASE: assert (!base_ok_o); // R9
    end
    if (base_ok_o) begin
      AST_BASE_NEEDS_VALID: assert (valid_i); // R2
    end
  end

endmodule

// File: rtl/pgchk_acc_ok.sv
module pgchk_acc_ok
  import pgchk_pkg::*;
(
  input  logic base_ok_i,
  input  acc_e kind_i,
  input  logic r_i,
  input  logic w_i,
  input  logic x_i,
  input  logic mxr_i,
  output logic pass_o
);

  logic kind_ok;

  always_comb begin
    unique case (kind_i)
      ACC_FETCH: kind_ok = x_i;
      ACC_LOAD:  kind_ok = r_i || (x_i && mxr_i);
      default:   kind_ok = w_i;
    endcase
    pass_o = base_ok_i && kind_ok;
  end

  always_comb begin
    if (pass_o && (kind_i == ACC_FETCH)) begin
      AST_FETCH_NEEDS_X: assert (x_i); // R5
    end
    if (pass_o && (kind_i == ACC_STORE)) begin
      AST_STORE_NEEDS_W: assert (w_i); // R7
    end
  end

endmodule

// File: rtl/pgchk_fault_gen.sv
module pgchk_fault_gen
  import pgchk_pkg::*;
#(
  parameter int CAUSE_W   = 5,
  parameter int CAUSE_IPF = 12,
  parameter int CAUSE_LPF = 13,
  parameter int CAUSE_SPF = 15
) (
  input  logic               pass_i,
  input  acc_e               kind_i,
  input  logic               amo_i,
  input  priv_e              cur_priv_i,
  output logic               grant_o,
  output logic [CAUSE_W-1:0] cause_o,
  output logic               tval_to_m_o
);

  localparam logic [CAUSE_W-1:0] C_IPF = CAUSE_W'(CAUSE_IPF);
  localparam logic [CAUSE_W-1:0] C_LPF = CAUSE_W'(CAUSE_LPF);
  localparam logic [CAUSE_W-1:0] C_SPF = CAUSE_W'(CAUSE_SPF);

  logic [CAUSE_W-1:0] fault_cause;
  logic               fault_to_m;

  always_comb begin
    unique case (kind_i)
      ACC_FETCH: begin
        fault_cause = C_IPF;
        fault_to_m  = 1'b0;
      end
      ACC_LOAD: begin
        fault_cause = amo_i ? C_SPF : C_LPF;
        fault_to_m  = (cur_priv_i == PRIV_M);
      end
      default: begin
        fault_cause = C_SPF;
        fault_to_m  = (cur_priv_i == PRIV_M);
      end
    endcase
    grant_o     = pass_i;
    cause_o     = pass_i ? '0 : fault_cause;
    tval_to_m_o = pass_i ? 1'b0 : fault_to_m;
  end

  always_comb begin
    if (!pass_i && (kind_i == ACC_FETCH)) begin
      AST_FETCH_TVAL_SUP: assert (!tval_to_m_o); // R8
    end
  end

endmodule

// File: rtl/page_perm_check.sv
module page_perm_check
  import pgchk_pkg::*;
#(
  parameter int CAUSE_W   = 5,
  parameter int CAUSE_IPF = 12,
  parameter int CAUSE_LPF = 13,
  parameter int CAUSE_SPF = 15
) (
  input  logic [PERM_W-1:0]  pte_perm_i,
  input  logic [1:0]         acc_kind_i,
  input  logic               amo_i,
  input  logic [1:0]         cur_priv_i,
  input  logic               mprv_i,
  input  logic [1:0]         mpp_i,
  input  logic               sum_i,
  input  logic               mxr_i,
  input  logic               force_fail_i,
  output logic               grant_o,
  output logic [CAUSE_W-1:0] cause_o,
  output logic               tval_to_m_o
);

  perm_t perm;
  acc_e  kind;
  priv_e cur_priv;
  priv_e prev_priv;
  priv_e eff_priv;
  logic  is_fetch;
  logic  base_ok;
  logic  pass;

  always_comb begin
    perm      = perm_t'(pte_perm_i);
    kind      = acc_e'(acc_kind_i);
    cur_priv  = priv_e'(cur_priv_i);
    prev_priv = priv_e'(mpp_i);
    is_fetch  = (kind == ACC_FETCH);
  end

  pgchk_mode_sel u_mode_sel (
    .cur_priv_i (cur_priv),
    .mpp_i      (prev_priv),
    .mprv_i     (mprv_i),
    .is_fetch_i (is_fetch),
    .eff_priv_o (eff_priv)
  );

  pgchk_base_ok u_base_ok (
    .valid_i      (perm.v),
    .user_i       (perm.u),
    .eff_priv_i   (eff_priv),
    .sum_i        (sum_i),
    .is_fetch_i   (is_fetch),
    .force_fail_i (force_fail_i),
    .base_ok_o    (base_ok)
  );

  pgchk_acc_ok u_acc_ok (
    .base_ok_i (base_ok),
    .kind_i    (kind),
    .r_i       (perm.r),
    .w_i       (perm.w),
    .x_i       (perm.x),
    .mxr_i     (mxr_i),
    .pass_o    (pass)
  );

  pgchk_fault_gen #(
    .CAUSE_W   (CAUSE_W),
    .CAUSE_IPF (CAUSE_IPF),
    .CAUSE_LPF (CAUSE_LPF),
    .CAUSE_SPF (CAUSE_SPF)
  ) u_fault_gen (
    .pass_i      (pass),
    .kind_i      (kind),
    .amo_i       (amo_i),
    .cur_priv_i  (cur_priv),
    .grant_o     (grant_o),
    .cause_o     (cause_o),
    .tval_to_m_o (tval_to_m_o)
  );

  always_comb begin
    if (grant_o) begin
      AST_GRANT_CLEAN: assert ((cause_o == '0) && !tval_to_m_o); // R10
    end
    if (force_fail_i) begin
      AST_FORCE_NO_GRANT: assert (!grant_o); // R9
    end
  end

endmodule

// File: tb/test_page_perm_check.sv
module test_page_perm_check;

  localparam logic [4:0] FV = 5'b00001;
  localparam logic [4:0] FR = 5'b00010;
  localparam logic [4:0] FW = 5'b00100;
  localparam logic [4:0] FX = 5'b01000;
  localparam logic [4:0] FU = 5'b10000;
  localparam logic [1:0] KF = 2'd0, KL = 2'd1, KS = 2'd2;
  localparam logic [1:0] PU = 2'd0, PS = 2'd1, PM = 2'd3;

  logic       clk;
  logic       rst_n;
  logic [4:0] pte_perm;
  logic [1:0] acc_kind;
  logic       amo;
  logic [1:0] cur_priv;
  logic       mprv;
  logic [1:0] mpp;
  logic       sum;
  logic       mxr;
  logic       force_fail;
  logic       grant;
  logic [4:0] cause;
  logic       tval_m;

  int total = 0;
  int bad   = 0;
  int cycles = 0;

  page_perm_check i_page_perm_check (
    .pte_perm_i   (pte_perm),
    .acc_kind_i   (acc_kind),
    .amo_i        (amo),
    .cur_priv_i   (cur_priv),
    .mprv_i       (mprv),
    .mpp_i        (mpp),
    .sum_i        (sum),
    .mxr_i        (mxr),
    .force_fail_i (force_fail),
    .grant_o      (grant),
    .cause_o      (cause),
    .tval_to_m_o  (tval_m)
  );

  initial clk = 1'b0;
  always #2.5 clk = ~clk;

  always @(posedge clk) begin
    cycles <= cycles + 1;
    if (cycles > 20000) begin
      bad = bad + 1;
      total = total + 1;
      $display("FAIL watchdog: run hung, actual cycles=%0d expected below 20000", cycles);
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  task automatic clear_ctl();
    amo = 0; mprv = 0; mpp = PU; sum = 0; mxr = 0; force_fail = 0;
  endtask

  task automatic apply_check(input string req, input logic [4:0] p, input logic [1:0] k,
                             input logic [1:0] cp, input logic eg, input logic [4:0] ec,
                             input logic em);
    @(posedge clk);
    pte_perm = p; acc_kind = k; cur_priv = cp;
    @(negedge clk);
    total = total + 1;
    if (grant !== eg || cause !== ec || tval_m !== em) begin
      bad = bad + 1;
      $display("FAIL %s: actual grant=%0b cause=%0d tval_m=%0b expected grant=%0b cause=%0d tval_m=%0b",
               req, grant, cause, tval_m, eg, ec, em);
    end
  endtask

  task automatic t_reset_state();
    clear_ctl();
    apply_check("R2 reset", 5'b0, KF, PU, 1'b0, 5'd12, 1'b0);
  endtask

  task automatic t_eff_mode();
    clear_ctl(); mprv = 1; mpp = PU;
    apply_check("R1 load under mprv", FV | FR, KL, PS, 1'b0, 5'd13, 1'b0);
    apply_check("R1 fetch ignores mprv", FV | FX, KF, PS, 1'b1, 5'd0, 1'b0);
    apply_check("R8 store mprv in M", FV | FW, KS, PM, 1'b0, 5'd15, 1'b1);
    mprv = 0;
    apply_check("R1 mprv off", FV | FR, KL, PS, 1'b1, 5'd0, 1'b0);
  endtask

  task automatic t_valid();
    clear_ctl();
    apply_check("R2 invalid M load", FR | FW | FX, KL, PM, 1'b0, 5'd13, 1'b1);
  endtask

  task automatic t_user_mode();
    clear_ctl();
    apply_check("R3 U no user bit", FV | FR, KL, PU, 1'b0, 5'd13, 1'b0);
    apply_check("R3 U user page", FV | FR | FU, KL, PU, 1'b1, 5'd0, 1'b0);
  endtask

  task automatic t_sup_user();
    clear_ctl();
    apply_check("R4 S user no sum", FV | FR | FU, KL, PS, 1'b0, 5'd13, 1'b0);
    sum = 1;
    apply_check("R4 S user sum", FV | FR | FU, KL, PS, 1'b1, 5'd0, 1'b0);
    apply_check("R4 S fetch user sum", FV | FX | FU, KF, PS, 1'b0, 5'd12, 1'b0);
    sum = 0;
    apply_check("R11 M user page", FV | FR | FU, KL, PM, 1'b1, 5'd0, 1'b0);
    apply_check("R11 M fetch user page", FV | FX | FU, KF, PM, 1'b1, 5'd0, 1'b0);
  endtask

  task automatic t_fetch();
    clear_ctl();
    apply_check("R5 fetch no x", FV | FR | FU, KF, PU, 1'b0, 5'd12, 1'b0);
    apply_check("R5 fetch x", FV | FX | FU, KF, PU, 1'b1, 5'd0, 1'b0);
    apply_check("R8 M fetch fault", FV | FR, KF, PM, 1'b0, 5'd12, 1'b0);
  endtask

  task automatic t_load();
    clear_ctl();
    apply_check("R6 x only no mxr", FV | FX, KL, PS, 1'b0, 5'd13, 1'b0);
    mxr = 1;
    apply_check("R6 x only mxr", FV | FX, KL, PS, 1'b1, 5'd0, 1'b0);
    mxr = 0; amo = 1;
    apply_check("R6 amo load fault", FV | FW, KL, PS, 1'b0, 5'd15, 1'b0);
    apply_check("R6 amo load ok", FV | FR, KL, PS, 1'b1, 5'd0, 1'b0);
  endtask

  task automatic t_store();
    clear_ctl();
    apply_check("R7 store no w", FV | FR | FX, KS, PS, 1'b0, 5'd15, 1'b0);
    apply_check("R7 store w", FV | FW, KS, PS, 1'b1, 5'd0, 1'b0);
    apply_check("R7 kind3 no w", FV | FR, 2'd3, PM, 1'b0, 5'd15, 1'b1);
  endtask

  task automatic t_force();
    clear_ctl(); force_fail = 1;
    apply_check("R9 force load", FV | FR | FW | FX | FU, KL, PM, 1'b0, 5'd13, 1'b1);
    apply_check("R9 force fetch", FV | FR | FW | FX | FU, KF, PM, 1'b0, 5'd12, 1'b0);
    apply_check("R9 force store", FV | FW, KS, PS, 1'b0, 5'd15, 1'b0);
    force_fail = 0;
    apply_check("R10 grant clean", FV | FR | FW | FX, KS, PM, 1'b1, 5'd0, 1'b0);
  endtask

  initial begin
    rst_n = 1'b0;
    pte_perm = '0; acc_kind = KF; cur_priv = PU;
    clear_ctl();
    repeat (3) @(posedge clk);
    rst_n = 1'b1;
    t_reset_state();
    t_eff_mode();
    t_valid();
    t_user_mode();
    t_sup_user();
    t_fetch();
    t_load();
    t_store();
    t_force();
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule